// File: doc/BRIEF.md
# Write-Back Data Cache with Range Maintenance

A set-associative, write-back data cache sits between a processor load/store port and a line-wide system memory port. Read misses fetch a whole line. Write hits stay in the cache and mark the line dirty. Write misses go straight to memory with their byte enables and do not allocate a line. When a line must be allocated, the cache takes an empty way if the set has one. Otherwise it evicts by a per-set round-robin pointer, and it writes back a dirty victim before it fetches the new line.

Software keeps a buffer coherent with a bus master that bypasses the cache by issuing maintenance commands over a byte range. A clean command writes every dirty cached line of the range to memory and keeps those lines valid. An invalidate command drops every cached line of the range without writing anything, so unsaved writes in those lines are lost. Each command visits the range one line at a time, looks up each line, skips lines that are not cached, and ends with a one-cycle done pulse. Only one operation runs at a time. The processor must hold its request and its address stable until it receives the acknowledge.

Top module: `wbc_cache`

## Requirements
- R1: After reset, the acknowledge, busy, done and both memory request valids are low.
- R2: A read miss issues exactly one line read at the line-aligned address and holds it stable until it is accepted. The data is returned only after the line arrives. Any later read of the same line completes with no memory traffic.
- R3: A write hit updates only the enabled bytes of the cached word. It issues no memory write, and a later read returns the merged word.
- R4: A write miss issues one memory write at the line address. Bit i of the mask covers byte i of the line, and only the written word's enabled bytes are set. No line is allocated, so a later read of that line misses.
- R5: On allocation, the lowest-numbered invalid way of the set is used. When no way is invalid, a per-set pointer that starts at way 0 picks the victim and advances by one; filling an invalid way leaves the pointer unchanged.
- R6: A valid dirty victim is written to memory with an all-ones mask before the read for the new line is issued.
- R7: Clean (operation code 0) writes each valid dirty line in the range to memory with an all-ones mask, clears its dirty bit and keeps it valid. A second clean of the same range writes nothing.
- R8: Invalidate (operation code 1) issues no memory write. Cached data in the range is discarded, and the next read of that range fetches from memory.
- R9: A command covers every line touched by the bytes [address, address+length). A length of 0 covers no line. Lines that are not cached cost no memory traffic. Completion is signalled by a done pulse exactly one cycle wide.
- R10: No acknowledge is given while a command is busy or while a line read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with acknowledge |
| mnt_start | input | 1 | Start a maintenance command |
| mnt_op | input | 1 | 0 = clean, 1 = invalidate |
| mnt_addr | input | ADDR_W | Range start byte address |
| mnt_len | input | LEN_W | Range length in bytes |
| mnt_busy | output | 1 | Command in progress |
| mnt_done | output | 1 | One-cycle completion pulse |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Line read accepted |
| mem_rd_addr | output | ADDR_W | Line read address |
| mem_rsp_valid | input | 1 | Line read data valid |
| mem_rsp_data | input | LINE_BYTES*8 | Line read data |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | ADDR_W | Line-aligned write address |
| mem_wr_data | output | LINE_BYTES*8 | Write data |
| mem_wr_mask | output | LINE_BYTES | Byte mask, bit i for byte i |

## Verification
The main function is exercised with four kinds of traffic: repeated reads of one line, full and partial stores that hit and that miss, fills that run a set past its associativity, and maintenance ranges that are unaligned, empty, or not cached at all. Counting memory reads separates hits from misses. The write address, the mask and the cycle of each write separate write-back, forwarding and discard. Re-reading a line after an eviction or an invalidate shows which way was chosen and whether the dirty data was kept or lost. The memory model stretches its ready signals over several cycles, so the hold-stable rules on the memory handshake are also exercised.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FREQ,
      ST_FWAIT,
      ST_WFWD,
      ST_WACK,
      ST_WALK,
      ST_WALK_WB,
      ST_WDONE
   } wbc_state_e;

   typedef enum logic {
      OP_CLEAN = 1'b0,
      OP_INVAL = 1'b1
   } wbc_op_e;

endpackage

// File: rtl/wbc_way_match.sv
module wbc_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 23
) (
   input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
   input  logic [WAYS-1:0]            set_valid,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [$clog2(WAYS)-1:0]    hit_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] way_eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign way_eq[w] = set_valid[w] && (set_tags[w] == look_tag);
   end

   assign hit = |way_eq;

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_eq[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
   parameter int WAYS = 4
) (
   input  logic [WAYS-1:0]         set_valid,
   input  logic [$clog2(WAYS)-1:0] rr_ptr,
   output logic [$clog2(WAYS)-1:0] victim,
   output logic                    use_rr
);
   localparam int WAY_W = $clog2(WAYS);

   always_comb begin
      victim = rr_ptr;
      use_rr = 1'b1;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!set_valid[w]) begin
            victim = WAY_W'(w);
            use_rr = 1'b0;
         end
      end
   end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int WAYS       = 4,
   parameter int SETS       = 16,
   parameter int LINE_BYTES = 32,
   parameter int LEN_W      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   input  logic [DATA_W/8-1:0]     cpu_be,
   output logic                    cpu_ack,
   output logic [DATA_W-1:0]       cpu_rdata,
   input  logic                    mnt_start,
   input  logic                    mnt_op,
   input  logic [ADDR_W-1:0]       mnt_addr,
   input  logic [LEN_W-1:0]        mnt_len,
   output logic                    mnt_busy,
   output logic                    mnt_done,
   output logic                    mem_rd_valid,
   input  logic                    mem_rd_ready,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic                    mem_rsp_valid,
   input  logic [LINE_BYTES*8-1:0] mem_rsp_data,
   output logic                    mem_wr_valid,
   input  logic                    mem_wr_ready,
   output logic [ADDR_W-1:0]       mem_wr_addr,
   output logic [LINE_BYTES*8-1:0] mem_wr_data,
   output logic [LINE_BYTES-1:0]   mem_wr_mask
);
   localparam int BE_W   = DATA_W / 8;
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int BOFF_W = $clog2(BE_W);
   localparam int WIDX_W = OFF_W - BOFF_W;
   localparam int WORDS  = LINE_BYTES / BE_W;
   localparam int SPAN_W = LEN_W + 1;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES <= BE_W) begin : g_bad_line
      $error("LINE_BYTES must be a power of two wider than the data port");
   end
   if (DATA_W % 8 != 0 || (1 << BOFF_W) != BE_W) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (LEN_W <= OFF_W || TAG_W < 1) begin : g_bad_len
      $error("LEN_W or ADDR_W too small for the line geometry");
   end

   // Storage
   logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
   logic [WAYS-1:0][LINE_W-1:0] data_q  [SETS];
   logic [WAYS-1:0]             valid_q [SETS];
   logic [WAYS-1:0]             dirty_q [SETS];
   logic [WAY_W-1:0]            rr_q    [SETS];

   // Control state
   wbc_state_e        st_q;
   wbc_op_e           op_q;
   logic [ADDR_W-1:0] cur_q;
   logic [SPAN_W-1:0] left_q;
   logic [WAY_W-1:0]  vic_q;
   logic [WAY_W-1:0]  mw_way_q;

   // Lookup path
   logic [ADDR_W-1:0] lk_addr;
   logic [SET_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;
   logic              hit;
   logic [WAY_W-1:0]  hit_way;
   logic [WAY_W-1:0]  vic_way;
   logic              vic_use_rr;

   assign lk_addr = (st_q == ST_WALK) ? cur_q : cpu_addr;
   assign lk_set  = lk_addr[OFF_W +: SET_W];
   assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];

   wbc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
      .set_tags (tag_q[lk_set]),
      .set_valid(valid_q[lk_set]),
      .look_tag (lk_tag),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   wbc_victim #(.WAYS(WAYS)) i_victim (
      .set_valid(valid_q[lk_set]),
      .rr_ptr   (rr_q[lk_set]),
      .victim   (vic_way),
      .use_rr   (vic_use_rr)
   );

   // Processor-side derived values
   logic [SET_W-1:0]      c_set;
   logic [TAG_W-1:0]      c_tag;
   logic [WIDX_W-1:0]     c_word;
   logic [LINE_BYTES-1:0] c_mask;
   logic [LINE_W-1:0]     c_wrep;
   logic [SET_W-1:0]      w_set;
   logic [LINE_W-1:0]     hit_line;

   assign c_set    = cpu_addr[OFF_W +: SET_W];
   assign c_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
   assign c_word   = cpu_addr[BOFF_W +: WIDX_W];
   assign c_mask   = LINE_BYTES'(cpu_be) << (c_word * BE_W);
   assign c_wrep   = {WORDS{cpu_wdata}};
   assign w_set    = cur_q[OFF_W +: SET_W];
   assign hit_line = data_q[lk_set][hit_way];

   // Maintenance range in lines
   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] n_lines;

   assign span    = {1'b0, mnt_len} + SPAN_W'(mnt_addr[OFF_W-1:0]) + SPAN_W'(LINE_BYTES - 1);
   assign n_lines = (mnt_len == '0) ? '0 : (span >> OFF_W);

   logic        idle_req;
   wbc_state_e  walk_next;

   assign idle_req  = (st_q == ST_IDLE) && cpu_req && !mnt_start;
   assign walk_next = (left_q == SPAN_W'(1)) ? ST_WDONE : ST_WALK;

   // Outputs
   assign cpu_ack      = (idle_req && hit) || (st_q == ST_WACK);
   assign cpu_rdata    = hit_line[c_word * DATA_W +: DATA_W];
   assign mnt_busy     = (st_q == ST_WALK) || (st_q == ST_WALK_WB) || (st_q == ST_WDONE);
   assign mnt_done     = (st_q == ST_WDONE);
   assign mem_rd_valid = (st_q == ST_FREQ);
   assign mem_rd_addr  = {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
   assign mem_wr_valid = (st_q == ST_EVICT) || (st_q == ST_WFWD) || (st_q == ST_WALK_WB);

   always_comb begin
      mem_wr_addr = cur_q;
      mem_wr_data = data_q[w_set][mw_way_q];
      mem_wr_mask = '1;
      unique case (st_q)
         ST_EVICT: begin
            mem_wr_addr = {tag_q[c_set][vic_q], c_set, OFF_W'(0)};
            mem_wr_data = data_q[c_set][vic_q];
         end
         ST_WFWD: begin
            mem_wr_addr = {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
            mem_wr_data = c_wrep;
            mem_wr_mask = c_mask;
         end
         default: ;
      endcase
   end

   // Control and line state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         op_q     <= OP_CLEAN;
         cur_q    <= '0;
         left_q   <= '0;
         vic_q    <= '0;
         mw_way_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
            rr_q[s]    <= '0;
         end
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (mnt_start) begin
                  op_q   <= wbc_op_e'(mnt_op);
                  cur_q  <= {mnt_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                  left_q <= n_lines;
                  st_q   <= (n_lines == '0) ? ST_WDONE : ST_WALK;
               end else if (cpu_req) begin
                  if (hit) begin
                     if (cpu_we) dirty_q[c_set][hit_way] <= 1'b1;
                  end else if (cpu_we) begin
                     st_q <= ST_WFWD;
                  end else begin
                     vic_q <= vic_way;
                     if (vic_use_rr) rr_q[c_set] <= rr_q[c_set] + WAY_W'(1);
                     st_q <= (valid_q[c_set][vic_way] && dirty_q[c_set][vic_way])
                             ? ST_EVICT : ST_FREQ;
                  end
               end
            end
            ST_EVICT: if (mem_wr_ready) st_q <= ST_FREQ;
            ST_FREQ:  if (mem_rd_ready) st_q <= ST_FWAIT;
            ST_FWAIT: begin
               if (mem_rsp_valid) begin
                  valid_q[c_set][vic_q] <= 1'b1;
                  dirty_q[c_set][vic_q] <= 1'b0;
                  st_q                  <= ST_IDLE;
               end
            end
            ST_WFWD: if (mem_wr_ready) st_q <= ST_WACK;
            ST_WACK: st_q <= ST_IDLE;
            ST_WALK: begin
               if (hit && op_q == OP_CLEAN && dirty_q[lk_set][hit_way]) begin
                  mw_way_q <= hit_way;
                  st_q     <= ST_WALK_WB;
               end else begin
                  if (hit && op_q == OP_INVAL) begin
                     valid_q[lk_set][hit_way] <= 1'b0;
                     dirty_q[lk_set][hit_way] <= 1'b0;
                  end
                  cur_q  <= cur_q + ADDR_W'(LINE_BYTES);
                  left_q <= left_q - SPAN_W'(1);
                  st_q   <= walk_next;
               end
            end
            ST_WALK_WB: begin
               if (mem_wr_ready) begin
                  dirty_q[w_set][mw_way_q] <= 1'b0;
                  cur_q  <= cur_q + ADDR_W'(LINE_BYTES);
                  left_q <= left_q - SPAN_W'(1);
                  st_q   <= walk_next;
               end
            end
            ST_WDONE: st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   // Tag and data arrays (no reset needed)
   always_ff @(posedge clk) begin
      if (st_q == ST_FWAIT && mem_rsp_valid) begin
         tag_q[c_set][vic_q]  <= c_tag;
         data_q[c_set][vic_q] <= mem_rsp_data;
      end else if (idle_req && hit && cpu_we) begin
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (c_mask[b]) data_q[c_set][hit_way][b*8 +: 8] <= c_wrep[b*8 +: 8];
         end
      end
   end

   // Assertions
   assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mnt_busy |-> !cpu_ack);
   assert_no_ack_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !cpu_ack);
   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
   assert_rd_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));
   assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_mask)));
   assert_fwd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mnt_busy && cpu_we) |-> ($countones(mem_wr_mask) <= BE_W));
   assert_inval_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_busy && op_q == OP_INVAL) |-> !mem_wr_valid);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mnt_done |=> !mnt_done);
endmodule

// File: tb/test_wbc_cache.sv
module test_wbc_cache;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]   cpu_be = '0;
   logic         cpu_ack;
   logic [31:0]  cpu_rdata;
   logic         mnt_start = 1'b0, mnt_op = 1'b0;
   logic [31:0]  mnt_addr = '0;
   logic [15:0]  mnt_len = '0;
   logic         mnt_busy, mnt_done;
   logic         mem_rd_valid, mem_rd_ready;
   logic [31:0]  mem_rd_addr;
   logic         mem_rsp_valid = 1'b0;
   logic [255:0] mem_rsp_data = '0;
   logic         mem_wr_valid, mem_wr_ready;
   logic [31:0]  mem_wr_addr;
   logic [255:0] mem_wr_data;
   logic [31:0]  mem_wr_mask;

   always #5 clk = ~clk;

   wbc_cache i_wbc_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .mnt_start(mnt_start), .mnt_op(mnt_op), .mnt_addr(mnt_addr), .mnt_len(mnt_len),
      .mnt_busy(mnt_busy), .mnt_done(mnt_done),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask)
   );

   // Memory model: 4 KiB of words
   logic [31:0] mem [1024];
   int cyc = 0, rd_cnt = 0, wr_cnt = 0, rd_cyc = 0, wr_cyc = 0;
   logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_mask = '0;
   int n_chk = 0, n_bad = 0;

   assign mem_rd_ready = (cyc % 2) == 0;
   assign mem_wr_ready = (cyc % 3) != 2;

   function automatic logic [31:0] iv(input logic [31:0] a);
      return 32'hA000_0000 | {a[31:2], 2'b00};
   endfunction

   function automatic logic [255:0] line_of(input logic [31:0] a);
      logic [255:0] r;
      for (int k = 0; k < 8; k++) r[k*32 +: 32] = mem[{a[11:5], 3'(k)}];
      return r;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= line_of(mem_rd_addr);
         rd_cnt        <= rd_cnt + 1;
         last_rd_addr  <= mem_rd_addr;
         rd_cyc        <= cyc;
      end
      if (mem_wr_valid && mem_wr_ready) begin
         for (int b = 0; b < 32; b++) begin
            if (mem_wr_mask[b])
               mem[{mem_wr_addr[11:5], 3'(b / 4)}][(b % 4)*8 +: 8] <= mem_wr_data[b*8 +: 8];
         end
         wr_cnt       <= wr_cnt + 1;
         last_wr_addr <= mem_wr_addr;
         last_wr_mask <= mem_wr_mask;
         wr_cyc       <= cyc;
      end
   end

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [31:0] rd, output int waits);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      waits = 0;
      #1;
      while (!cpu_ack && waits < 2000) begin
         @(negedge clk); #1;
         waits++;
      end
      rd = cpu_rdata;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] v);
      int w;
      cpu_op(1'b0, a, 32'h0, 4'h0, v, w);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
      logic [31:0] v;
      int w;
      cpu_op(1'b1, a, d, be, v, w);
   endtask

   task automatic mnt(input logic op, input logic [31:0] a, input logic [15:0] len,
                      output int pulses);
      @(negedge clk);
      mnt_start = 1'b1; mnt_op = op; mnt_addr = a; mnt_len = len;
      @(negedge clk);
      mnt_start = 1'b0;
      pulses = 0;
      for (int i = 0; i < 2000; i++) begin
         if (mnt_done) pulses++;
         if (!mnt_busy && pulses > 0) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check("R1 ack after reset", cpu_ack, 0);
      check("R1 busy after reset", mnt_busy, 0);
      check("R1 done after reset", mnt_done, 0);
      check("R1 rd valid after reset", mem_rd_valid, 0);
      check("R1 wr valid after reset", mem_wr_valid, 0);
   endtask

   task automatic t_read_miss;
      logic [31:0] v;
      int r0, w;
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h104, 0, 0, v, w);
      check("R2 miss data", v, iv(32'h104));
      check("R2 one line read", rd_cnt - r0, 1);
      check("R2 aligned address", last_rd_addr, 32'h100);
      check("R10 stalled until fill", w >= 2, 1);
      rd(32'h11C, v);
      check("R2 hit data", v, iv(32'h11C));
      check("R2 hit no traffic", rd_cnt - r0, 1);
   endtask

   task automatic t_write_hit;
      logic [31:0] v;
      int w0;
      w0 = wr_cnt;
      wr(32'h108, 32'hDEAD_BEEF, 4'hF);
      wr(32'h10C, 32'h0000_5500, 4'b0010);
      check("R3 no write-through", wr_cnt - w0, 0);
      rd(32'h108, v);
      check("R3 full word merged", v, 32'hDEAD_BEEF);
      rd(32'h10C, v);
      check("R3 byte merged", v, (iv(32'h10C) & 32'hFFFF_00FF) | 32'h0000_5500);
      check("R3 memory untouched", mem[32'h108 >> 2], iv(32'h108));
   endtask

   task automatic t_write_miss;
      logic [31:0] v;
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      wr(32'h204, 32'h1234_5678, 4'hF);
      check("R4 one write", wr_cnt - w0, 1);
      check("R4 line address", last_wr_addr, 32'h200);
      check("R4 mask word1", last_wr_mask, 32'h0000_00F0);
      check("R4 memory updated", mem[32'h204 >> 2], 32'h1234_5678);
      wr(32'h30C, 32'h00AB_0000, 4'b0100);
      check("R4 mask single byte", last_wr_mask, 32'h0000_4000);
      check("R4 byte in memory", mem[32'h30C >> 2], (iv(32'h30C) & 32'hFF00_FFFF) | 32'h00AB_0000);
      check("R4 no allocation, no read", rd_cnt - r0, 0);
      rd(32'h204, v);
      check("R4 later read misses", rd_cnt - r0, 1);
      check("R4 later read value", v, 32'h1234_5678);
   endtask

   task automatic t_clean;
      logic [31:0] v;
      int w0, r0, p;
      w0 = wr_cnt; r0 = rd_cnt;
      mnt(1'b0, 32'h110, 16'd4, p);
      check("R7 one line written", wr_cnt - w0, 1);
      check("R7 line address", last_wr_addr, 32'h100);
      check("R7 full mask", last_wr_mask, 32'hFFFF_FFFF);
      check("R7 data in memory", mem[32'h108 >> 2], 32'hDEAD_BEEF);
      check("R9 clean done pulse", p, 1);
      rd(32'h108, v);
      check("R7 line stays valid", rd_cnt - r0, 0);
      mnt(1'b0, 32'h100, 16'd32, p);
      check("R7 second clean silent", wr_cnt - w0, 1);
   endtask

   task automatic t_inval;
      logic [31:0] v;
      int w0, r0, p;
      wr(32'h118, 32'h0BAD_F00D, 4'hF);
      w0 = wr_cnt; r0 = rd_cnt;
      mnt(1'b1, 32'h100, 16'd32, p);
      check("R8 no write", wr_cnt - w0, 0);
      check("R8 memory keeps old", mem[32'h118 >> 2], iv(32'h118));
      check("R9 inval done pulse", p, 1);
      rd(32'h118, v);
      check("R8 refetch", rd_cnt - r0, 1);
      check("R8 dirty data lost", v, iv(32'h118));
   endtask

   task automatic t_range;
      logic [31:0] v;
      int w0, p;
      rd(32'h040, v);
      rd(32'h060, v);
      wr(32'h044, 32'h1111_1111, 4'hF);
      wr(32'h064, 32'h2222_2222, 4'hF);
      w0 = wr_cnt;
      mnt(1'b0, 32'h05C, 16'd8, p);
      check("R9 two lines cleaned", wr_cnt - w0, 2);
      check("R9 first line saved", mem[32'h044 >> 2], 32'h1111_1111);
      check("R9 second line saved", mem[32'h064 >> 2], 32'h2222_2222);
      wr(32'h048, 32'h3333_3333, 4'hF);
      w0 = wr_cnt;
      mnt(1'b0, 32'h040, 16'd0, p);
      check("R9 zero length no write", wr_cnt - w0, 0);
      check("R9 zero length done", p, 1);
      mnt(1'b1, 32'hE00, 16'd64, p);
      check("R9 absent lines no write", wr_cnt - w0, 0);
      check("R9 absent lines done", p, 1);
      rd(32'h048, v);
      check("R9 zero length kept data", v, 32'h3333_3333);
   endtask

   task automatic t_victim;
      logic [31:0] v;
      int w0, r0, p;
      rd(32'h0A0, v); rd(32'h2A0, v); rd(32'h4A0, v); rd(32'h6A0, v);
      wr(32'h0A0, 32'hCAFE_0001, 4'hF);
      w0 = wr_cnt; r0 = rd_cnt;
      rd(32'h8A0, v);
      check("R6 dirty victim written", wr_cnt - w0, 1);
      check("R6 victim address way0", last_wr_addr, 32'h0A0);
      check("R6 victim full mask", last_wr_mask, 32'hFFFF_FFFF);
      check("R6 write before read", wr_cyc < rd_cyc, 1);
      check("R6 victim data saved", mem[32'h0A0 >> 2], 32'hCAFE_0001);
      check("R5 new line data", v, iv(32'h8A0));
      w0 = wr_cnt;
      rd(32'hAA0, v);
      check("R5 clean victim no write", wr_cnt - w0, 0);
      r0 = rd_cnt;
      rd(32'h4A0, v);
      check("R5 way2 kept", rd_cnt - r0, 0);
      rd(32'h2A0, v);
      check("R5 way1 evicted by round-robin", rd_cnt - r0, 1);
      rd(32'h6A0, v);
      check("R5 way3 kept", rd_cnt - r0, 1);
      mnt(1'b1, 32'h8A0, 16'd4, p);
      rd(32'hCA0, v);
      r0 = rd_cnt;
      rd(32'h6A0, v);
      check("R5 invalid way preferred", rd_cnt - r0, 0);
      rd(32'hAA0, v);
      check("R5 other ways kept", rd_cnt - r0, 0);
   endtask

   task automatic t_hold_off;
      logic [31:0] v;
      int seen_done = 0, bad_ack = 0, got = 0;
      wr(32'h108, 32'h5555_AAAA, 4'hF);
      @(negedge clk);
      mnt_start = 1'b1; mnt_op = 1'b0; mnt_addr = 32'h0; mnt_len = 16'h200;
      @(negedge clk);
      mnt_start = 1'b0;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h108;
      for (int i = 0; i < 2000 && got == 0; i++) begin
         #1;
         if (cpu_ack && mnt_busy) bad_ack++;
         if (mnt_done) seen_done++;
         if (cpu_ack) begin
            got = 1;
            v = cpu_rdata;
         end else begin
            @(negedge clk);
         end
      end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      check("R10 no ack while busy", bad_ack, 0);
      check("R10 ack after done", seen_done, 1);
      check("R10 read completes", v, 32'h5555_AAAA);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 | (i << 2);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_read_miss;
      t_write_hit;
      t_write_miss;
      t_clean;
      t_inval;
      t_range;
      t_victim;
      t_hold_off;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule